// File: doc/BRIEF.md
# Complementary Half-Bridge Gate Generator

This block drives the two gates of a half-bridge switch pair from a base clock. A tick counter runs through one switching period of a programmable length. The period is split into two halves. The first half holds the high-side conduction interval and the second half holds the low-side one. Each interval lasts half the programmed duty count and sits in the middle of its half. The rest of the half is dead time, during which neither switch conducts. Because of this, the duty setting directly sets the dead time.

The period and duty inputs are plain control pins. They are sampled only when a new period starts, so a change made part-way through a period takes effect at the next boundary and never produces a shortened pulse. Duty values are clamped into a safe window. The lower bound keeps the dead time short enough for soft switching. The upper bound keeps at least one dead tick between the two conduction intervals. With the defaults, a period of 75 ticks gives the nominal switching rate, and each tick of duty is one step of control resolution.

Top module: `hb_gate_gen`

## Requirements
- R1: While `en` is low, `gate_hi`, `gate_lo` and `period_start` are all low from the first clock edge that samples `en` low.
- R2: On the first edge that samples `en` high after it was low (or after reset), the counter restarts at tick 0 and `period_start` is high for that tick. `period_start` is then high for exactly one tick in every period.
- R3: The effective period P is `period_cnt`, raised to `PERIOD_MIN` (default 8) when smaller.
- R4: The effective duty D is `duty_cnt` clamped to [Dlo, P-2]. Dlo is ceil(P*`DUTY_MIN_PCT`/100), default 84, limited to at most P-2.
- R5: With ON = floor(D/2) and H = floor(P/2), `gate_hi` is high exactly on ticks a to a+ON-1, where a = floor((H-ON)/2).
- R6: The low half spans ticks H to P-1, so an odd P gives the extra tick to the low half. `gate_lo` is high exactly on ticks H+b to H+b+ON-1, where b = floor((P-H-ON)/2).
- R7: `gate_hi` and `gate_lo` are never high together. A gate never rises on the tick directly after the other gate was high.
- R8: `period_cnt` and `duty_cnt` are captured only at tick 0. Changes at any other tick have no effect on the gates until the next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces both gates off |
| period_cnt | input | CNT_W | Requested switching period in ticks |
| duty_cnt | input | CNT_W | Requested total conduction ticks per period |
| gate_hi | output | 1 | High-side gate |
| gate_lo | output | 1 | Low-side gate |
| period_start | output | 1 | High on tick 0 of each period |

## Verification
The hardest case to reach is a settings change that arrives in the middle of a running period. It has to be seen to leave the rest of that period untouched and then take effect exactly at the boundary. The stimulus waits for a `period_start`, waits a fixed number of ticks, and then changes both period and duty. The bench model takes its settings only at its own boundaries, so any early load shows up as a gate mismatch. The corners of the clamping rules are also driven: a period below the minimum, where the duty window collapses to a single value, and duty requests below and above the window.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DEAD = 2'd1,
    PH_HI   = 2'd2,
    PH_LO   = 2'd3
  } hbg_phase_e;
endpackage

// File: rtl/hbg_setting_calc.sv
module hbg_setting_calc #(
  parameter int CNT_W        = 8,
  parameter int PERIOD_MIN   = 8,
  parameter int DUTY_MIN_PCT = 84
) (
  input  logic [CNT_W-1:0] period_raw,
  input  logic [CNT_W-1:0] duty_raw,
  output logic [CNT_W-1:0] last_tick,
  output logic [CNT_W-1:0] hi_start,
  output logic [CNT_W-1:0] hi_stop,
  output logic [CNT_W-1:0] lo_start,
  output logic [CNT_W-1:0] lo_stop
);
  localparam int PW = CNT_W + 8;
  localparam logic [CNT_W-1:0] PMIN = CNT_W'(PERIOD_MIN);

  logic [CNT_W-1:0] p, dmax, dmin_raw, dlo, d, on_t, h_hi, h_lo, lead_hi, lead_lo;
  logic [PW-1:0]    prod;

  always_comb begin
    p        = (period_raw < PMIN) ? PMIN : period_raw;
    dmax     = p - CNT_W'(2);
    prod     = PW'(p) * PW'(DUTY_MIN_PCT) + PW'(99);
    dmin_raw = CNT_W'(prod / PW'(100));
    dlo      = (dmin_raw > dmax) ? dmax : dmin_raw;
    if (duty_raw < dlo)       d = dlo;
    else if (duty_raw > dmax) d = dmax;
    else                      d = duty_raw;
    on_t     = d >> 1;
    h_hi     = p >> 1;
    h_lo     = p - h_hi;
    lead_hi  = (h_hi - on_t) >> 1;
    lead_lo  = (h_lo - on_t) >> 1;
    last_tick = p - CNT_W'(1);
    hi_start  = lead_hi;
    hi_stop   = lead_hi + on_t;
    lo_start  = h_hi + lead_lo;
    lo_stop   = h_hi + lead_lo + on_t;
  end
endmodule

// File: rtl/hbg_tick_counter.sv
module hbg_tick_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] nxt_last,
  input  logic [CNT_W-1:0] nxt_hi_start,
  input  logic [CNT_W-1:0] nxt_hi_stop,
  input  logic [CNT_W-1:0] nxt_lo_start,
  input  logic [CNT_W-1:0] nxt_lo_stop,
  output logic             run,
  output logic [CNT_W-1:0] tick,
  output logic [CNT_W-1:0] cur_hi_start,
  output logic [CNT_W-1:0] cur_hi_stop,
  output logic [CNT_W-1:0] cur_lo_start,
  output logic [CNT_W-1:0] cur_lo_stop
);
  logic [CNT_W-1:0] cur_last;
  logic             wrap;

  assign wrap = !run || (tick == cur_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run          <= 1'b0;
      tick         <= '0;
      cur_last     <= '0;
      cur_hi_start <= '0;
      cur_hi_stop  <= '0;
      cur_lo_start <= '0;
      cur_lo_stop  <= '0;
    end else if (!en) begin
      run  <= 1'b0;
      tick <= '0;
    end else if (wrap) begin
      run          <= 1'b1;
      tick         <= '0;
      cur_last     <= nxt_last;
      cur_hi_start <= nxt_hi_start;
      cur_hi_stop  <= nxt_hi_stop;
      cur_lo_start <= nxt_lo_start;
      cur_lo_stop  <= nxt_lo_stop;
    end else begin
      tick <= tick + CNT_W'(1);
    end
  end
endmodule

// File: rtl/hbg_phase_decode.sv
module hbg_phase_decode
  import hbg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             run,
  input  logic [CNT_W-1:0] tick,
  input  logic [CNT_W-1:0] hi_start,
  input  logic [CNT_W-1:0] hi_stop,
  input  logic [CNT_W-1:0] lo_start,
  input  logic [CNT_W-1:0] lo_stop,
  output hbg_phase_e       phase
);
  always_comb begin
    if (!run)                                  phase = PH_IDLE;
    else if (tick >= hi_start && tick < hi_stop) phase = PH_HI;
    else if (tick >= lo_start && tick < lo_stop) phase = PH_LO;
    else                                       phase = PH_DEAD;
  end
endmodule

// File: rtl/hb_gate_gen.sv
module hb_gate_gen
  import hbg_pkg::*;
#(
  parameter int CNT_W        = 8,
  parameter int PERIOD_MIN   = 8,
  parameter int DUTY_MIN_PCT = 84
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_cnt,
  input  logic [CNT_W-1:0] duty_cnt,
  output logic             gate_hi,
  output logic             gate_lo,
  output logic             period_start
);
  logic [CNT_W-1:0] n_last, n_hs, n_he, n_ls, n_le;
  logic [CNT_W-1:0] c_hs, c_he, c_ls, c_le, tick;
  logic             run;
  hbg_phase_e       phase;

  hbg_setting_calc #(
    .CNT_W(CNT_W), .PERIOD_MIN(PERIOD_MIN), .DUTY_MIN_PCT(DUTY_MIN_PCT)
  ) u_calc (
    .period_raw(period_cnt), .duty_raw(duty_cnt),
    .last_tick(n_last), .hi_start(n_hs), .hi_stop(n_he),
    .lo_start(n_ls), .lo_stop(n_le)
  );

  hbg_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en),
    .nxt_last(n_last), .nxt_hi_start(n_hs), .nxt_hi_stop(n_he),
    .nxt_lo_start(n_ls), .nxt_lo_stop(n_le),
    .run(run), .tick(tick),
    .cur_hi_start(c_hs), .cur_hi_stop(c_he),
    .cur_lo_start(c_ls), .cur_lo_stop(c_le)
  );

  hbg_phase_decode #(.CNT_W(CNT_W)) u_dec (
    .run(run), .tick(tick),
    .hi_start(c_hs), .hi_stop(c_he), .lo_start(c_ls), .lo_stop(c_le),
    .phase(phase)
  );

  assign gate_hi      = (phase == PH_HI);
  assign gate_lo      = (phase == PH_LO);
  assign period_start = run && (tick == '0);
endmodule

// File: rtl/hb_gate_gen_chk.sv
module hb_gate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic gate_hi,
  input logic gate_lo,
  input logic period_start
);
  p_gates_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  p_lo_after_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hi |=> !gate_lo);

  p_hi_after_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gate_lo |=> !gate_hi);

  p_idle_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!gate_hi && !gate_lo && !period_start));

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !period_start && !gate_hi && !gate_lo && $rose(en)) |=> period_start);

  p_start_not_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> !gate_lo);
endmodule

bind hb_gate_gen hb_gate_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .period_start(period_start)
);

// File: tb/hb_gate_gen_test.sv
module hb_gate_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] period_cnt = 8'd75;
  logic [7:0] duty_cnt = 8'd70;
  logic       gate_hi, gate_lo, period_start;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  hb_gate_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .period_cnt(period_cnt), .duty_cnt(duty_cnt),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .period_start(period_start)
  );

  // behavioural model
  int m_run = 0, m_cnt = 0, m_p = 0, m_d = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0;
    end else if (!en) begin
      m_run = 0; m_cnt = 0;
    end else if (m_run == 0 || m_cnt == m_p - 1) begin
      int p, dlo;
      p = (period_cnt < 8) ? 8 : int'(period_cnt);
      dlo = (p * 84 + 99) / 100;
      if (dlo > p - 2) dlo = p - 2;
      m_p = p;
      if (int'(duty_cnt) < dlo) m_d = dlo;
      else if (int'(duty_cnt) > p - 2) m_d = p - 2;
      else m_d = duty_cnt;
      m_run = 1; m_cnt = 0;
    end else begin
      m_cnt++;
    end
  end

  logic prev_hi = 1'b0, prev_lo = 1'b0;

  always @(negedge clk) begin
    int on_t, hh, hl, a, b;
    logic e_hi, e_lo, e_st;
    cyc++;
    on_t = m_d / 2; hh = m_p / 2; hl = m_p - hh;
    a = (hh - on_t) / 2; b = (hl - on_t) / 2;
    e_hi = (m_run != 0) && m_cnt >= a && m_cnt < a + on_t;
    e_lo = (m_run != 0) && m_cnt >= hh + b && m_cnt < hh + b + on_t;
    e_st = (m_run != 0) && m_cnt == 0;
    n_cmp++;
    if ({gate_hi, gate_lo, period_start} !== {e_hi, e_lo, e_st}) begin
      n_bad++;
      $display("FAIL %s (R5/R6 gates, R2 strobe) t=%0d got hi/lo/st=%b%b%b exp %b%b%b",
               tag, cyc, gate_hi, gate_lo, period_start, e_hi, e_lo, e_st);
    end
    n_cmp++;
    if ((gate_hi && (gate_lo || prev_lo)) || (gate_lo && prev_hi)) begin
      n_bad++;
      $display("FAIL R7 overlap t=%0d got hi=%b lo=%b prev=%b%b exp separated",
               cyc, gate_hi, gate_lo, prev_hi, prev_lo);
    end
    prev_hi = gate_hi; prev_lo = gate_lo;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog t=%0d got running exp done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_cfg(input int p, input int d);
    @(negedge clk); #1;
    period_cnt = 8'(p); duty_cnt = 8'(d);
  endtask

  initial begin
    tag = "R1 reset";
    run_cycles(3);
    #1 rst_n = 1'b1;
    run_cycles(5);
    tag = "R2 R5 R6 odd period";
    set_cfg(75, 70);
    en = 1'b1;
    run_cycles(230);
    tag = "R4 duty below window";
    set_cfg(75, 10);
    run_cycles(160);
    tag = "R4 duty above window";
    set_cfg(75, 255);
    run_cycles(160);
    tag = "R3 period below minimum";
    set_cfg(3, 50);
    run_cycles(40);
    tag = "R6 even period";
    set_cfg(20, 18);
    run_cycles(60);
    tag = "R8 mid-period change";
    set_cfg(75, 66);
    while (period_start !== 1'b1) @(negedge clk);
    run_cycles(11);
    set_cfg(40, 36);
    run_cycles(140);
    tag = "R1 R2 disable mid-period";
    set_cfg(200, 180);
    run_cycles(230);
    @(negedge clk); #1 en = 1'b0;
    run_cycles(10);
    @(negedge clk); #1 en = 1'b1;
    run_cycles(420);
    tag = "R4 long period";
    set_cfg(255, 0);
    run_cycles(520);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule